// File: doc/BRIEF.md
# Disk Controller Command/Result Sequencer

This block is the CPU-facing byte engine of a floppy-style disk controller. An 8-bit CPU port reaches two registers: a main status byte (port select 0) and a data byte (port select 1). Software polls the status byte. It then writes an opcode and its parameters, one byte per poll, into the data register. When the last parameter arrives, the whole command goes to an execution back end through a start/done handshake. Once the back end finishes, the CPU reads the result bytes out of the same data register.

An internal table gives each opcode its length in bytes (the opcode byte included), its number of result bytes, and whether a successful finish raises the interrupt line. Seek-type commands leave a pending report per drive. A sense request collects that report later. A separate run input models the controller's own reset pin. While run is low the port is inert. When run rises, the controller restarts and reports every drive as needing attention.

Top module: `fdc_cmd_seq`

## Requirements
- R1: After `rst_n` is released, the status byte reads 0x00, `irq` is 0, and `be_start` is 0.
- R2: The status byte is {RQM, DIO, 0, BUSY, drive-busy[3:0]}, with bit 7 = RQM, bit 6 = DIO, bit 5 = 0 and bit 4 = BUSY. After a status read, RQM is 1 when `ctl_run` is high and no command is waiting on the back end.
- R3: A data write is accepted only when run, RQM and not DIO all hold. A data read is accepted only when run, RQM and DIO all hold. A rejected read returns 0x00. A rejected write changes nothing that is visible.
- R4: Every accepted data read or data write clears RQM.
- R5: A write accepted while BUSY is 0 starts a command. Its opcode is the byte AND 0x1F, and BUSY sets. Table: 0x03 has 3 bytes and no results; 0x04 has 2 bytes and 1 result; 0x06 has 9 bytes and 7 results and interrupts; 0x07 has 2 bytes and no results, interrupts, and is seek-type; 0x0A has 2 bytes and 7 results and interrupts; 0x0F has 3 bytes and no results, interrupts, and is seek-type; 0x08 is sense. Every other opcode is invalid.
- R6: The cycle after the final command byte, `be_start` pulses for one cycle. `be_cmd` then holds the bytes as written (byte k in bits 8k+7:8k) and `be_len` holds the length.
- R7: On a successful finish, BUSY clears if the opcode has no results. Otherwise DIO sets, and the back end's result bytes are read out in order.
- R8: On a failed finish, BUSY and DIO clear and `irq` keeps its value.
- R9: A successful finish of an interrupting opcode sets `irq`. Reading the first result byte clears it.
- R10: An invalid opcode enters the result phase at once (status 0xD0 with drive bits), and its single result byte is 0x80.
- R11: A successful seek-type command on drive d (byte 1 bits 1:0) sets drive-busy bit d and stores result bytes 0 and 1. Sense returns the two stored bytes of the lowest-numbered drive with a stored report, and clears that drive's bit and `irq`. If no report is stored, sense returns the single byte 0x80. Any other successful command on drive d discards d's stored report.
- R12: While `ctl_run` is low, RQM and `irq` are held at 0 and data accesses are refused. When `ctl_run` rises, the status byte becomes 0x80, `irq` sets, and every drive d holds the report {0xC0+d, 0x00}.
- R13: After the final result byte is read, BUSY and DIO clear, and the next write starts a new command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low chip reset |
| ctl_run | input | 1 | Controller run (low holds the controller in reset) |
| cpu_rd | input | 1 | CPU read strobe, one cycle per access |
| cpu_wr | input | 1 | CPU write strobe, one cycle per access |
| cpu_sel | input | 1 | 0 selects status, 1 selects data |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_rdata | output | 8 | CPU read byte, valid during the read cycle |
| be_start | output | 1 | One-cycle command hand-off |
| be_cmd | output | 72 | Command bytes, byte k in bits 8k+7:8k |
| be_len | output | 4 | Command length in bytes |
| be_done | input | 1 | Back end finish pulse |
| be_ok | input | 1 | Finish status, 1 = success |
| be_res | input | 72 | Result bytes, byte k in bits 8k+7:8k |
| irq | output | 1 | Interrupt line |

## Verification
The bench sweeps every 5-bit opcode. Invalid codes, all with high bits set, separate the mask and the 0x80 path from real commands. Each valid opcode is run to completion to check its length, result count and interrupt flag. Seek-type commands on different drives, followed by sense, show the lowest-drive priority and the stored bytes, and an interleaved non-seek command shows that a stored report is discarded. Three kinds of misuse show that the gating works: writes without a fresh poll, writes during the result phase, and a failed back end finish. Dropping run in the middle of a command shows the restart behaviour.

// File: rtl/fdc_seq_pkg.sv
package fdc_seq_pkg;
  localparam int BYTE_W = 8;
  localparam int NUM_DRIVES = 4;
  localparam logic [7:0] OP_MASK = 8'h1F;
  localparam logic [4:0] OP_SENSE = 5'h08;
  localparam logic [7:0] BAD_CODE = 8'h80;

  typedef struct packed {
    logic [3:0] clen;
    logic [3:0] rlen;
    logic       irq;
    logic       seek;
  } op_info_t;

  function automatic op_info_t op_lookup(input logic [4:0] op);
    op_info_t r;
    r = '0;
    case (op)
      5'h03: r = '{clen: 4'd3, rlen: 4'd0, irq: 1'b0, seek: 1'b0};
      5'h04: r = '{clen: 4'd2, rlen: 4'd1, irq: 1'b0, seek: 1'b0};
      5'h06: r = '{clen: 4'd9, rlen: 4'd7, irq: 1'b1, seek: 1'b0};
      5'h07: r = '{clen: 4'd2, rlen: 4'd0, irq: 1'b1, seek: 1'b1};
      5'h0A: r = '{clen: 4'd2, rlen: 4'd7, irq: 1'b1, seek: 1'b0};
      5'h0F: r = '{clen: 4'd3, rlen: 4'd0, irq: 1'b1, seek: 1'b1};
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic logic [7:0] status_byte(input logic rqm, input logic dio,
                                             input logic busy, input logic [3:0] drv);
    return {rqm, dio, 1'b0, busy, drv};
  endfunction
endpackage

// File: rtl/fdc_sense_slots.sv
module fdc_sense_slots #(
  parameter int N = 4,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm_all,
  input  logic          wr_en,
  input  logic          wr_full,
  input  logic [IW-1:0] wr_idx,
  input  logic [7:0]    wr_b0,
  input  logic [7:0]    wr_b1,
  input  logic          take,
  output logic          any_full,
  output logic [IW-1:0] pick_idx,
  output logic [7:0]    pick_b0,
  output logic [7:0]    pick_b1
);
  logic [N-1:0] full;
  logic [7:0]   sb0 [N];
  logic [7:0]   sb1 [N];

  for (genvar g = 0; g < N; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        full[g] <= 1'b0;
        sb0[g]  <= '0;
        sb1[g]  <= '0;
      end else if (arm_all) begin
        full[g] <= 1'b1;
        sb0[g]  <= 8'hC0 | 8'(g);
        sb1[g]  <= '0;
      end else if (take && pick_idx == IW'(g)) begin
        full[g] <= 1'b0;
      end else if (wr_en && wr_idx == IW'(g)) begin
        full[g] <= wr_full;
        if (wr_full) begin
          sb0[g] <= wr_b0;
          sb1[g] <= wr_b1;
        end
      end
    end
  end

  always_comb begin
    any_full = 1'b0;
    pick_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (full[i]) begin
        any_full = 1'b1;
        pick_idx = IW'(i);
      end
    end
    pick_b0 = sb0[pick_idx];
    pick_b1 = sb1[pick_idx];
  end
endmodule

// File: rtl/fdc_res_buf.sv
module fdc_res_buf #(
  parameter int DEPTH = 9,
  parameter int CW = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_be,
  input  logic [DEPTH*8-1:0] be_res,
  input  logic               load_pair,
  input  logic [7:0]         p0,
  input  logic [7:0]         p1,
  input  logic [CW-1:0]      rd_idx,
  output logic [7:0]         rd_byte
);
  logic [7:0] rb [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n) rb[g] <= '0;
      else if (load_be) rb[g] <= be_res[g*8 +: 8];
      else if (load_pair) begin
        if (g == 0) rb[g] <= p0;
        else if (g == 1) rb[g] <= p1;
      end
    end
  end

  always_comb begin
    rd_byte = '0;
    for (int i = 0; i < DEPTH; i++)
      if (rd_idx == CW'(i)) rd_byte = rb[i];
  end
endmodule

// File: rtl/fdc_cmd_seq.sv
module fdc_cmd_seq
  import fdc_seq_pkg::*;
#(
  parameter int BUF_DEPTH = 9,
  localparam int CNT_W = $clog2(BUF_DEPTH + 1),
  localparam int DRV_W = $clog2(NUM_DRIVES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ctl_run,
  input  logic                   cpu_rd,
  input  logic                   cpu_wr,
  input  logic                   cpu_sel,
  input  logic [7:0]             cpu_wdata,
  output logic [7:0]             cpu_rdata,
  output logic                   be_start,
  output logic [BUF_DEPTH*8-1:0] be_cmd,
  output logic [3:0]             be_len,
  input  logic                   be_done,
  input  logic                   be_ok,
  input  logic [BUF_DEPTH*8-1:0] be_res,
  output logic                   irq
);
  logic rqm, dio, busy, pending, irq_q, run_q, start_q;
  logic [NUM_DRIVES-1:0] drv_busy;
  logic [4:0]       opcode;
  logic [CNT_W-1:0] ccnt, rcnt, rlen;
  logic [7:0]       cmd_buf [BUF_DEPTH];

  // named events shared with the checker
  logic ev_st_rd, ev_wr_ok, ev_rd_ok, ev_new_cmd, ev_direct, ev_sense, ev_last_byte;
  logic ev_done, ev_done_ok, ev_fail, ev_last_res, ev_first_res, run_rise;
  logic [4:0]       op_w;
  logic [CNT_W-1:0] ccnt_w;
  op_info_t         info_w, info_cur;
  logic             any_full;
  logic [DRV_W-1:0] pick_idx, done_drv;
  logic [7:0]       pick_b0, pick_b1, res_byte;
  logic [7:0]       status;
  logic             sense_hit;

  assign run_rise     = ctl_run & ~run_q;
  assign ev_st_rd     = cpu_rd & ~cpu_sel;
  assign ev_wr_ok     = cpu_wr & cpu_sel & ctl_run & rqm & ~dio;
  assign ev_rd_ok     = cpu_rd & cpu_sel & ctl_run & rqm & dio;
  assign ev_new_cmd   = ev_wr_ok & ~busy;
  assign op_w         = ev_new_cmd ? 5'(cpu_wdata & OP_MASK) : opcode;
  assign info_w       = op_lookup(op_w);
  assign info_cur     = op_lookup(opcode);
  assign ccnt_w       = ev_new_cmd ? '0 : ccnt;
  assign ev_direct    = ev_wr_ok & (info_w.clen == 4'd0);
  assign ev_sense     = ev_direct & (op_w == OP_SENSE);
  assign sense_hit    = ev_sense & any_full;
  assign ev_last_byte = ev_wr_ok & (info_w.clen != 4'd0) &
                        ((ccnt_w + CNT_W'(1)) == CNT_W'(info_w.clen));
  assign ev_done      = be_done & pending & ctl_run & run_q;
  assign ev_done_ok   = ev_done & be_ok;
  assign ev_fail      = ev_done & ~be_ok;
  assign ev_last_res  = ev_rd_ok & ((rcnt + CNT_W'(1)) >= rlen);
  assign ev_first_res = ev_rd_ok & (rcnt == '0);
  assign done_drv     = cmd_buf[1][DRV_W-1:0];

  assign status    = status_byte(rqm, dio, busy, drv_busy);
  assign cpu_rdata = ev_st_rd ? status : (ev_rd_ok ? res_byte : 8'h00);
  assign be_start  = start_q;
  assign be_len    = info_cur.clen;
  assign irq       = irq_q;

  for (genvar g = 0; g < BUF_DEPTH; g++) begin : g_cmd_out
    assign be_cmd[g*8 +: 8] = cmd_buf[g];
  end

  fdc_sense_slots #(.N(NUM_DRIVES)) u_slots (
    .clk(clk), .rst_n(rst_n), .arm_all(run_rise),
    .wr_en(ev_done_ok), .wr_full(info_cur.seek), .wr_idx(done_drv),
    .wr_b0(be_res[7:0]), .wr_b1(be_res[15:8]),
    .take(sense_hit), .any_full(any_full), .pick_idx(pick_idx),
    .pick_b0(pick_b0), .pick_b1(pick_b1)
  );

  fdc_res_buf #(.DEPTH(BUF_DEPTH), .CW(CNT_W)) u_res (
    .clk(clk), .rst_n(rst_n),
    .load_be(ev_done_ok && info_cur.rlen != 4'd0), .be_res(be_res),
    .load_pair(ev_direct),
    .p0(sense_hit ? pick_b0 : BAD_CODE), .p1(sense_hit ? pick_b1 : 8'h00),
    .rd_idx(rcnt), .rd_byte(res_byte)
  );

  for (genvar g = 0; g < BUF_DEPTH; g++) begin : g_cmd_buf
    always_ff @(posedge clk) begin
      if (!rst_n) cmd_buf[g] <= '0;
      else if (ev_wr_ok && !ev_direct && ccnt_w == CNT_W'(g)) cmd_buf[g] <= cpu_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rqm <= 1'b0; dio <= 1'b0; busy <= 1'b0; pending <= 1'b0;
      irq_q <= 1'b0; run_q <= 1'b0; start_q <= 1'b0;
      drv_busy <= '0; opcode <= '0; ccnt <= '0; rcnt <= '0; rlen <= '0;
    end else begin
      run_q   <= ctl_run;
      start_q <= 1'b0;
      if (!ctl_run) begin
        rqm   <= 1'b0;
        irq_q <= 1'b0;
      end else if (run_rise) begin
        rqm <= 1'b1; dio <= 1'b0; busy <= 1'b0; pending <= 1'b0;
        drv_busy <= '0; ccnt <= '0; rcnt <= '0; irq_q <= 1'b1;
      end else begin
        if (ev_st_rd && !pending) rqm <= 1'b1;
        if (ev_wr_ok) begin
          rqm <= 1'b0;
          if (ev_new_cmd) begin
            opcode <= op_w;
            busy   <= 1'b1;
          end
          if (ev_direct) begin
            dio  <= 1'b1;
            rcnt <= '0;
            rlen <= sense_hit ? CNT_W'(2) : CNT_W'(1);
            if (sense_hit) begin
              drv_busy[pick_idx] <= 1'b0;
              irq_q <= 1'b0;
            end
          end else begin
            ccnt <= ccnt_w + CNT_W'(1);
            if (ev_last_byte) begin
              pending <= 1'b1;
              start_q <= 1'b1;
            end
          end
        end
        if (ev_rd_ok) begin
          rqm <= 1'b0;
          if (ev_first_res) irq_q <= 1'b0;
          if (ev_last_res) begin
            busy <= 1'b0; dio <= 1'b0; rcnt <= '0;
          end else begin
            rcnt <= rcnt + CNT_W'(1);
          end
        end
        if (ev_done) begin
          pending <= 1'b0;
          if (be_ok) begin
            if (info_cur.irq) irq_q <= 1'b1;
            if (info_cur.seek) drv_busy[done_drv] <= 1'b1;
            if (info_cur.rlen == 4'd0) busy <= 1'b0;
            else begin
              dio  <= 1'b1;
              rcnt <= '0;
              rlen <= CNT_W'(info_cur.rlen);
            end
          end else begin
            busy <= 1'b0;
            dio  <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/fdc_seq_checker.sv
module fdc_seq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_run,
  input logic       cpu_rd,
  input logic       cpu_sel,
  input logic [7:0] cpu_rdata,
  input logic       rqm,
  input logic       dio,
  input logic       busy,
  input logic       pending,
  input logic       irq_q,
  input logic       be_start,
  input logic       ev_st_rd,
  input logic       ev_wr_ok,
  input logic       ev_rd_ok,
  input logic       ev_last_byte,
  input logic       ev_fail,
  input logic       ev_first_res
);
  assert_poll_rearms_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_st_rd && ctl_run && !pending) |=> rqm);

  assert_rejected_read_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && cpu_sel && !ev_rd_ok) |-> cpu_rdata == 8'h00);

  assert_access_drops_rqm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wr_ok || ev_rd_ok) |=> !rqm);

  assert_start_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_last_byte |=> (be_start && pending));

  assert_start_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    be_start |=> !be_start);

  assert_dio_in_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dio |-> busy);

  assert_fail_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fail |=> (!busy && !dio && irq_q == $past(irq_q)));

  assert_first_res_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_first_res |=> !irq_q);

  assert_halt_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_run |=> (!rqm && !irq_q));
endmodule

bind fdc_cmd_seq fdc_seq_checker u_seq_chk (
  .clk(clk), .rst_n(rst_n), .ctl_run(ctl_run), .cpu_rd(cpu_rd), .cpu_sel(cpu_sel),
  .cpu_rdata(cpu_rdata), .rqm(rqm), .dio(dio), .busy(busy), .pending(pending),
  .irq_q(irq_q), .be_start(be_start), .ev_st_rd(ev_st_rd), .ev_wr_ok(ev_wr_ok),
  .ev_rd_ok(ev_rd_ok), .ev_last_byte(ev_last_byte), .ev_fail(ev_fail),
  .ev_first_res(ev_first_res)
);

// File: tb/test_fdc_cmd_seq.sv
module test_fdc_cmd_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_run = 1'b0;
  logic cpu_rd = 1'b0, cpu_wr = 1'b0, cpu_sel = 1'b0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic be_start;
  logic [71:0] be_cmd;
  logic [3:0] be_len;
  logic be_done = 1'b0, be_ok = 1'b0;
  logic [71:0] be_res = '0;
  logic irq;

  int total = 0, bad = 0, start_cnt = 0;
  logic tb_ok = 1'b1;
  logic [7:0] cap [9];
  logic [3:0] cap_len;
  logic [7:0] tx [9];
  logic [3:0] drv_bits = '0;
  logic [3:0] slot_full = '0;
  logic [7:0] slot_b0 [4];
  logic [7:0] slot_b1 [4];
  logic exp_irq = 1'b0;

  always #2.5 clk = ~clk;

  fdc_cmd_seq i_fdc_cmd_seq (
    .clk(clk), .rst_n(rst_n), .ctl_run(ctl_run), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_sel(cpu_sel), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .be_start(be_start), .be_cmd(be_cmd), .be_len(be_len), .be_done(be_done),
    .be_ok(be_ok), .be_res(be_res), .irq(irq)
  );

  function automatic int tb_len(input logic [4:0] op);
    case (op)
      5'h03, 5'h0F: return 3;
      5'h04, 5'h07, 5'h0A: return 2;
      5'h06: return 9;
      default: return 0;
    endcase
  endfunction
  function automatic int tb_rlen(input logic [4:0] op);
    return (op == 5'h04) ? 1 : ((op == 5'h06 || op == 5'h0A) ? 7 : 0);
  endfunction
  function automatic logic tb_irq(input logic [4:0] op);
    return op == 5'h06 || op == 5'h07 || op == 5'h0A || op == 5'h0F;
  endfunction
  function automatic logic tb_seek(input logic [4:0] op);
    return op == 5'h07 || op == 5'h0F;
  endfunction
  function automatic logic [7:0] res_val(input logic [7:0] c0, input logic [7:0] c1, input int i);
    return (c1 ^ 8'(i * 17)) + c0;
  endfunction

  // back end model
  initial begin
    forever begin
      @(negedge clk);
      if (be_start) begin
        start_cnt++;
        cap_len = be_len;
        for (int i = 0; i < 9; i++) cap[i] = be_cmd[i*8 +: 8];
        repeat (3) @(negedge clk);
        be_done = 1'b1;
        be_ok = tb_ok;
        for (int i = 0; i < 9; i++) be_res[i*8 +: 8] = res_val(cap[0], cap[1], i);
        @(negedge clk);
        be_done = 1'b0;
      end
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic st_rd(output logic [7:0] v);
    @(negedge clk); cpu_rd = 1'b1; cpu_sel = 1'b0;
    #1 v = cpu_rdata;
    @(posedge clk); #1 cpu_rd = 1'b0;
  endtask
  task automatic dt_rd(output logic [7:0] v);
    @(negedge clk); cpu_rd = 1'b1; cpu_sel = 1'b1;
    #1 v = cpu_rdata;
    @(posedge clk); #1 cpu_rd = 1'b0;
  endtask
  task automatic dt_wr(input logic [7:0] b);
    @(negedge clk); cpu_wr = 1'b1; cpu_sel = 1'b1; cpu_wdata = b;
    @(posedge clk); #1 cpu_wr = 1'b0;
  endtask

  task automatic drain(input int n, input string req);
    logic [7:0] v;
    for (int i = 0; i < n; i++) begin
      st_rd(v); dt_rd(v);
      chk(req, v, res_val(tx[0], tx[1], i));
      if (i == 0) begin
        exp_irq = 1'b0;
        chk("R9 first result clears irq", 8'(irq), 8'(exp_irq));
      end
    end
    st_rd(v); chk("R13 idle after last result", v, {4'h0, drv_bits});
    st_rd(v); chk("R2 poll sets RQM", v, {4'h8, drv_bits});
  endtask

  task automatic sense;
    logic [7:0] v;
    int k;
    k = -1;
    for (int i = 3; i >= 0; i--) if (slot_full[i]) k = i;
    st_rd(v); dt_wr(8'h08);
    if (k >= 0) begin
      slot_full[k] = 1'b0; drv_bits[k] = 1'b0; exp_irq = 1'b0;
    end
    st_rd(v); st_rd(v); chk("R11 sense result phase", v, {4'hD, drv_bits});
    chk("R11 sense clears irq", 8'(irq), 8'(exp_irq));
    st_rd(v); dt_rd(v);
    chk("R11 sense byte 0", v, (k >= 0) ? slot_b0[k] : 8'h80);
    if (k >= 0) begin
      st_rd(v); dt_rd(v); chk("R11 sense byte 1", v, slot_b1[k]);
    end
    st_rd(v); chk("R13 idle after sense", v, {4'h0, drv_bits});
  endtask

  task automatic run_cmd(input logic [7:0] op0, input logic [7:0] b1, input logic ok);
    logic [7:0] v;
    int n, rl, s0;
    logic [4:0] op;
    op = op0[4:0];
    n = tb_len(op); rl = tb_rlen(op);
    for (int i = 0; i < 9; i++) tx[i] = (i == 0) ? op0 : ((i == 1) ? b1 : 8'(i * 3 + 5));
    tb_ok = ok; s0 = start_cnt;
    for (int i = 0; i < n; i++) begin
      st_rd(v); dt_wr(tx[i]);
    end
    repeat (8) @(negedge clk);
    chk("R6 one start pulse", 8'(start_cnt - s0), 8'd1);
    chk("R6 length", 8'(cap_len), 8'(n));
    for (int i = 0; i < n; i++) chk("R6 command byte", cap[i], tx[i]);
    if (ok) begin
      if (tb_irq(op)) exp_irq = 1'b1;
      if (tb_seek(op)) begin
        drv_bits[b1[1:0]] = 1'b1; slot_full[b1[1:0]] = 1'b1;
        slot_b0[b1[1:0]] = res_val(tx[0], tx[1], 0);
        slot_b1[b1[1:0]] = res_val(tx[0], tx[1], 1);
      end else slot_full[b1[1:0]] = 1'b0;
    end
    chk(ok ? "R9 irq after finish" : "R8 irq kept on failure", 8'(irq), 8'(exp_irq));
    st_rd(v); st_rd(v);
    if (!ok) chk("R8 failure returns idle", v, {4'h8, drv_bits});
    else if (rl == 0) chk("R7 no-result command idle", v, {4'h8, drv_bits});
    else begin
      chk("R7 result phase status", v, {4'hD, drv_bits});
      drain(rl, "R7 result byte");
    end
    tb_ok = 1'b1;
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    st_rd(v); chk("R1 status after reset", v, 8'h00);
    chk("R1 irq after reset", 8'(irq), 8'h00);
    chk("R1 no start after reset", 8'(be_start), 8'h00);
    dt_rd(v); chk("R3 read refused while halted", v, 8'h00);

    ctl_run = 1'b1;
    for (int i = 0; i < 4; i++) begin
      slot_full[i] = 1'b1; slot_b0[i] = 8'hC0 + 8'(i); slot_b1[i] = 8'h00;
    end
    exp_irq = 1'b1;
    repeat (2) @(negedge clk);
    st_rd(v); chk("R12 status after run rises", v, 8'h80);
    chk("R12 irq after run rises", 8'(irq), 8'h01);
    for (int i = 0; i < 5; i++) sense;

    // invalid opcode sweep, high bits set to exercise the mask
    for (int op = 0; op < 32; op++) begin
      if (tb_len(5'(op)) == 0 && op != 8) begin
        st_rd(v); dt_wr(8'hE0 | 8'(op));
        st_rd(v); st_rd(v); chk("R10 invalid enters result phase", v, 8'hD0);
        if (op == 1) begin
          dt_wr(8'h55);
          st_rd(v); chk("R3 write during result phase ignored", v, 8'hD0);
        end
        dt_rd(v); chk("R10 invalid result byte", v, 8'h80);
        st_rd(v); chk("R13 idle after invalid", v, 8'h00);
      end
    end
    dt_rd(v); chk("R3 read refused while DIO low", v, 8'h00);

    // write without a fresh poll is refused
    st_rd(v); dt_wr(8'h04); dt_wr(8'h02);
    st_rd(v); chk("R4 access drops RQM", v, 8'h10);
    tx[0] = 8'h04; tx[1] = 8'h01;
    dt_wr(8'h01);
    repeat (8) @(negedge clk);
    chk("R3 unpolled write ignored", cap[1], 8'h01);
    st_rd(v); st_rd(v); chk("R7 status result phase", v, 8'hD0);
    drain(1, "R7 drive status byte");

    run_cmd(8'hE4, 8'h03, 1'b1);   // R5 masked opcode
    run_cmd(8'h03, 8'h00, 1'b1);
    run_cmd(8'h06, 8'h00, 1'b1);
    run_cmd(8'h0A, 8'h01, 1'b0);   // R8 failure
    run_cmd(8'h0A, 8'h01, 1'b1);
    run_cmd(8'h0F, 8'h02, 1'b1);
    run_cmd(8'h07, 8'h03, 1'b1);
    sense;                          // R11 drive 2 first
    sense;
    run_cmd(8'h0F, 8'h01, 1'b1);
    run_cmd(8'h04, 8'h01, 1'b1);    // R11 discards drive 1 report
    sense;

    // run dropped in the middle of a command
    st_rd(v); dt_wr(8'h06); st_rd(v); dt_wr(8'h00);
    @(negedge clk); ctl_run = 1'b0;
    repeat (2) @(negedge clk);
    chk("R12 irq low while halted", 8'(irq), 8'h00);
    st_rd(v); chk("R12 RQM low while halted", v & 8'h80, 8'h00);
    dt_rd(v); chk("R12 data refused while halted", v, 8'h00);
    ctl_run = 1'b1;
    drv_bits = '0; exp_irq = 1'b1;
    for (int i = 0; i < 4; i++) begin
      slot_full[i] = 1'b1; slot_b0[i] = 8'hC0 + 8'(i); slot_b1[i] = 8'h00;
    end
    repeat (2) @(negedge clk);
    st_rd(v); chk("R12 restart status", v, 8'h80);
    chk("R12 restart irq", 8'(irq), 8'h01);
    for (int i = 0; i < 5; i++) sense;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule